// File: doc/BRIEF.md
# Address Window Decoder with Translation

This block sits on the inbound side of a bus bridge and decides which of a small set of address windows an access falls into. Each window keeps a base, a mask, a translation value, a translation-enable bit and an address-space bit. The base, mask and translation value each hold `DEC_BITS` bits and apply only to the upper `DEC_BITS` bits of the 32-bit address. The block compares the start address of each access against every implemented window and reports the winner on a one-hot vector. It also gives the outbound address, with the upper bits translated when the winning window asks for it.

The access begins when `acc_strobe` rises. The hit vector and outbound address appear after `WAIT_STATES` further clock edges (1, 2 or 3). They then hold until the strobe falls. A narrow register write port loads the per-window fields. All fields reset to parameter values, so the bridge can decode before any software runs.

Top module: `addr_window_decoder`

## Requirements
- R1: A window matches when the upper `DEC_BITS` address bits equal its base on every bit position where its effective mask is 1. Positions where the mask is 0 are ignored.
- R2: A window matches only when its space bit equals `acc_io`, where 0 means memory and 1 means IO.
- R3: A window whose mask is all zeros never matches, whatever its base.
- R4: For a window whose space bit is 0 (memory), the lowest decoded mask bit is treated as 0. A memory window is therefore at least two minimum-sized windows wide.
- R5: With `XLAT_IMPL`=1 and the winner's translation-enable bit set, each upper address bit is taken from the translation value where the effective mask is 1, and from the input address where it is 0. The low `32-DEC_BITS` bits always pass through.
- R6: With `XLAT_IMPL`=0, the outbound address equals the input address whatever the enable bits hold.
- R7: The first clock edge with `acc_strobe` high starts the access. `hit` and `out_addr` change at edge number `WAIT_STATES` after it, and are all-zero before that.
- R8: When several windows match, only the lowest-numbered one is set in `hit`. With no match, `hit` is zero and `out_addr` equals the input address.
- R9: Once loaded, `hit` and `out_addr` hold while `acc_strobe` stays high. The clock edge that sees `acc_strobe` low clears both to zero.
- R10: A register write made at or after the start edge of an access does not change that access's result. It applies from the next access on.
- R11: After reset, every field equals its per-window parameter value, and `hit` and `out_addr` are zero.
- R12: The write port loads window `reg_img` when `reg_we` is 1. The field is chosen by `reg_sel`: 0 base, 1 mask, 2 translation value, 3 control. Base, mask and translation come from `reg_wdata[31:32-DEC_BITS]`. For control, bit 0 is translation enable and bit 1 is the space bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_img | input | $clog2(NUM_IMG) | Window selected for the write |
| reg_sel | input | 2 | Field selected for the write |
| reg_wdata | input | 32 | Write data |
| acc_strobe | input | 1 | Access in progress |
| acc_addr | input | 32 | Access address, held for the whole access |
| acc_io | input | 1 | Access space: 0 memory, 1 IO |
| hit | output | NUM_IMG | One-hot window hit |
| out_addr | output | 32 | Outbound (translated) address |

## Verification
The bench builds two copies with four windows and `DEC_BITS`=8, so a short vector list covers every upper-byte case. The first copy has `WAIT_STATES`=2 and translation built in. The second has `WAIT_STATES`=3 and translation left out. Both receive the same stimulus, so one access checks latency, the pass-through variant and the priority together. The reset values place a small memory window inside a larger translating one, give one IO window an all-ones mask, and leave one window unimplemented. This covers overlap priority, exact IO matching, the memory lowest-bit rule and the disabled window.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_IMG     = 4,
  parameter int DEC_BITS    = 20,
  parameter int WAIT_STATES = 1,
  parameter bit XLAT_IMPL   = 1'b1,
  parameter logic [NUM_IMG*DEC_BITS-1:0] BASE_RST = '0,
  parameter logic [NUM_IMG*DEC_BITS-1:0] MASK_RST = '0,
  parameter logic [NUM_IMG*DEC_BITS-1:0] XLAT_RST = '0,
  parameter logic [NUM_IMG-1:0]          XEN_RST  = '0,
  parameter logic [NUM_IMG-1:0]          SPC_RST  = '0,
  localparam int IW = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [IW-1:0]      reg_img,
  input  logic [1:0]         reg_sel,
  input  logic [31:0]        reg_wdata,
  input  logic               acc_strobe,
  input  logic [31:0]        acc_addr,
  input  logic               acc_io,
  output logic [NUM_IMG-1:0] hit,
  output logic [31:0]        out_addr
);
  localparam int DB = DEC_BITS;
  localparam logic [DB-1:0] LOW1 = DB'(1);

  logic [DB-1:0] base_q [NUM_IMG];
  logic [DB-1:0] mask_q [NUM_IMG];
  logic [DB-1:0] xlat_q [NUM_IMG];
  logic [NUM_IMG-1:0] xen_q, spc_q;

  logic [DB-1:0] a_hi;
  logic [DB-1:0] em   [NUM_IMG];
  logic [DB-1:0] xl   [NUM_IMG];
  logic [NUM_IMG-1:0] match;
  logic [NUM_IMG-1:0] dec_hit;
  logic [31:0] dec_addr;

  logic               active, done;
  logic [1:0]         cnt;
  logic [NUM_IMG-1:0] pend_hit;
  logic [31:0]        pend_addr;

  assign a_hi = acc_addr[31 -: DB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IMG; i++) begin
        base_q[i] <= BASE_RST[i*DB +: DB];
        mask_q[i] <= MASK_RST[i*DB +: DB];
        xlat_q[i] <= XLAT_RST[i*DB +: DB];
      end
      xen_q <= XEN_RST;
      spc_q <= SPC_RST;
    end else if (reg_we && (32'(reg_img) < NUM_IMG)) begin
      case (reg_sel)
        2'd0: base_q[reg_img] <= reg_wdata[31 -: DB];
        2'd1: mask_q[reg_img] <= reg_wdata[31 -: DB];
        2'd2: xlat_q[reg_img] <= reg_wdata[31 -: DB];
        default: begin
          xen_q[reg_img] <= reg_wdata[0];
          spc_q[reg_img] <= reg_wdata[1];
        end
      endcase
    end
  end

  for (genvar g = 0; g < NUM_IMG; g++) begin : g_img
    assign em[g]    = spc_q[g] ? mask_q[g] : (mask_q[g] & ~LOW1);
    assign match[g] = (|mask_q[g]) && (spc_q[g] == acc_io) &&
                      (((a_hi ^ base_q[g]) & em[g]) == '0);
    assign xl[g]    = (XLAT_IMPL && xen_q[g]) ? ((a_hi & ~em[g]) | (xlat_q[g] & em[g])) : a_hi;
  end

  always_comb begin
    dec_hit  = '0;
    dec_addr = acc_addr;
    for (int i = NUM_IMG - 1; i >= 0; i--) begin
      if (match[i]) begin
        dec_hit           = '0;
        dec_hit[i]        = 1'b1;
        dec_addr[31 -: DB] = xl[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      done      <= 1'b0;
      cnt       <= '0;
      pend_hit  <= '0;
      pend_addr <= '0;
      hit       <= '0;
      out_addr  <= '0;
    end else if (!acc_strobe) begin
      active   <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      hit      <= '0;
      out_addr <= '0;
    end else if (!active) begin
      active    <= 1'b1;
      cnt       <= 2'd1;
      pend_hit  <= dec_hit;
      pend_addr <= dec_addr;
    end else if (!done) begin
      if (cnt == 2'(WAIT_STATES)) begin
        hit      <= pend_hit;
        out_addr <= pend_addr;
        done     <= 1'b1;
      end else begin
        cnt <= cnt + 2'd1;
      end
    end
  end
endmodule

module addr_window_decoder_chk #(
  parameter int NUM_IMG     = 4,
  parameter int WAIT_STATES = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_strobe,
  input logic [NUM_IMG-1:0] hit,
  input logic [31:0]        out_addr
);
  // R8
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
  // R9
  strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_strobe |=> (hit == '0) && (out_addr == '0));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && (|hit)) |=> $stable(hit) && $stable(out_addr));
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|hit) |-> $past(acc_strobe, WAIT_STATES + 1));
endmodule

bind addr_window_decoder addr_window_decoder_chk #(
  .NUM_IMG(NUM_IMG), .WAIT_STATES(WAIT_STATES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .hit(hit), .out_addr(out_addr)
);

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
  localparam int N  = 4;
  localparam int DB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_img = '0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic acc_strobe = 1'b0;
  logic [31:0] acc_addr = '0;
  logic acc_io = 1'b0;
  logic [N-1:0] hit, hit2;
  logic [31:0] out_addr, out2;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  localparam logic [N*DB-1:0] BR = {8'h40, 8'h10, 8'h20, 8'h10};
  localparam logic [N*DB-1:0] MR = {8'h00, 8'hF0, 8'hFF, 8'hFC};
  localparam logic [N*DB-1:0] XR = {8'h00, 8'hA0, 8'h00, 8'h00};

  addr_window_decoder #(.NUM_IMG(N), .DEC_BITS(DB), .WAIT_STATES(2), .XLAT_IMPL(1'b1),
    .BASE_RST(BR), .MASK_RST(MR), .XLAT_RST(XR), .XEN_RST(4'b0100), .SPC_RST(4'b0010)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_img(reg_img), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .acc_strobe(acc_strobe), .acc_addr(acc_addr), .acc_io(acc_io),
    .hit(hit), .out_addr(out_addr));

  addr_window_decoder #(.NUM_IMG(N), .DEC_BITS(DB), .WAIT_STATES(3), .XLAT_IMPL(1'b0),
    .BASE_RST(BR), .MASK_RST(MR), .XLAT_RST(XR), .XEN_RST(4'b0100), .SPC_RST(4'b0010)) dut_nx (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_img(reg_img), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .acc_strobe(acc_strobe), .acc_addr(acc_addr), .acc_io(acc_io),
    .hit(hit2), .out_addr(out2));

  // {addr, io, expected hit, expected translated address}
  localparam int NV = 8;
  localparam logic [68:0] VEC [NV] = '{
    {32'h1234_5678, 1'b0, 4'b0001, 32'h1234_5678},  // R8 overlap, lowest wins
    {32'h1734_5678, 1'b0, 4'b0100, 32'hA734_5678},  // R5 translated
    {32'h2000_0010, 1'b1, 4'b0010, 32'h2000_0010},  // R2 IO match
    {32'h2000_0010, 1'b0, 4'b0000, 32'h2000_0010},  // R2 space mismatch
    {32'h2100_0000, 1'b1, 4'b0000, 32'h2100_0000},  // R1 all-ones mask
    {32'h1234_0000, 1'b1, 4'b0000, 32'h1234_0000},  // R2 memory windows, IO access
    {32'h4000_0000, 1'b0, 4'b0000, 32'h4000_0000},  // R3 zero mask
    {32'h1D00_0000, 1'b0, 4'b0100, 32'hAD00_0000}   // R1 R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] img, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_img = img; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run(input logic [31:0] a, input logic io, input logic [N-1:0] eh,
                     input logic [31:0] eo, input string req);
    @(negedge clk);
    acc_strobe = 1'b1; acc_addr = a; acc_io = io;
    @(negedge clk);
    check({req, " R7 early"}, 32'(hit), 32'(0));
    check({req, " R7 early nx"}, 32'(hit2), 32'(0));
    @(negedge clk);
    check({req, " R7 early"}, 32'(hit), 32'(0));
    @(negedge clk);
    check({req, " hit"}, 32'(hit), 32'(eh));
    check({req, " addr"}, out_addr, eo);
    check({req, " R7 nx early"}, 32'(hit2), 32'(0));
    @(negedge clk);
    check({req, " R9 hold"}, 32'(hit), 32'(eh));
    check({req, " R9 hold addr"}, out_addr, eo);
    check({req, " R7 nx hit"}, 32'(hit2), 32'(eh));
    check({req, " R6 nx addr"}, out2, a);
    acc_strobe = 1'b0;
    @(negedge clk);
    check({req, " R9 clear"}, 32'(hit), 32'(0));
    check({req, " R9 clear addr"}, out_addr, 32'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 outputs zero after reset
    check("R11 hit", 32'(hit), 32'(0));
    check("R11 addr", out_addr, 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 hit after release", 32'(hit), 32'(0));

    for (int i = 0; i < NV; i++)
      run(VEC[i][68:37], VEC[i][36], VEC[i][35:32], VEC[i][31:0], $sformatf("R11 vec%0d", i));

    // R4: memory window with all-ones mask ignores its lowest decoded bit
    wr(2'd3, 2'd1, 32'hFF00_0000);
    run(32'h4100_0000, 1'b0, 4'b1000, 32'h4100_0000, "R4 R12 mem");
    wr(2'd3, 2'd3, 32'h0000_0002);
    run(32'h4100_0000, 1'b1, 4'b0000, 32'h4100_0000, "R4 R12 io exact miss");
    run(32'h4000_0000, 1'b1, 4'b1000, 32'h4000_0000, "R4 R12 io exact hit");

    // R12 translation value and enable writes
    wr(2'd2, 2'd2, 32'h3000_0000);
    run(32'h1734_5678, 1'b0, 4'b0100, 32'h3734_5678, "R5 R12 new xlat");
    wr(2'd2, 2'd3, 32'h0000_0000);
    run(32'h1734_5678, 1'b0, 4'b0100, 32'h1734_5678, "R5 R12 xen off");

    // R10: write during an access waits for the next access
    @(negedge clk);
    acc_strobe = 1'b1; acc_addr = 32'h5000_0000; acc_io = 1'b0;
    wr(2'd0, 2'd0, 32'h5000_0000);
    repeat (3) @(negedge clk);
    check("R10 current access unchanged", 32'(hit), 32'(0));
    acc_strobe = 1'b0;
    @(negedge clk);
    run(32'h5000_0000, 1'b0, 4'b0001, 32'h5000_0000, "R10 next access");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule